// File: doc/BRIEF.md
# Watchdog and Periodic Alarm Down Counter

This block is a 24-bit down counter that works either as a repeating alarm or as a watchdog. In alarm mode it counts once per slow (1 Hz) tick. Each time it reaches zero it raises an alarm flag, reloads a stored seed value and keeps running. In watchdog mode it counts on the fast (4096 Hz) tick. When it reaches zero it raises the flag and stops. The tick enables come from outside, and the serial bus, oscillator and pad drivers are not part of this block.

Software sees a small byte-wide register window made of three counter bytes, a control byte and a status byte. Writing the counter loads the live count and the seed together. Reading or writing a counter byte while the block is enabled restarts the count from the seed, which is how software services the watchdog. On expiry the block can request one of two pulses, each 1024 fast ticks long. The first is an active-low reset request, during which bus access is blocked. The second is an active-low interrupt request. In both cases the flag clears when the pulse ends.

Top module: `awt_top`

## Requirements
- R1: After reset the control byte, the status byte and all counter bits are 0, both request outputs are high and `access_inhibit` is low.
- R2: Writes to byte offsets 0 and 1 only stage data. A write to offset 2 (the most significant byte) loads `{offset2, offset1, offset0}` into the live count and the seed in one step. A read of offset 0 returns the live low byte and latches all 24 bits. Reads of offsets 1 and 2 return bytes of that latched value.
- R3: In alarm mode (control bit 1 = 0) the count drops by one per `tick_1hz` and ignores `tick_4096hz`. The step from 1 to 0 sets the flag (status bit 0) and reloads the seed, and counting continues.
- R4: In watchdog mode (control bit 1 = 1) the count drops by one per `tick_4096hz` and ignores `tick_1hz`. The step from 1 to 0 sets the flag and leaves the count stopped at 0.
- R5: With enable (control bit 0) set, any read or write of a counter byte reloads the live count from the seed.
- R6: With enable clear, the count never changes on any tick, and the counter bytes behave as plain storage.
- R7: With enable set, loading an all-zero value stops the counter, and the flag is never set.
- R8: On expiry with steering (control bit 2) at 0, `rst_req_n` is low for exactly 1024 `tick_4096hz` ticks and `access_inhibit` is high for the same time. Reads and writes are ignored during that window. The flag clears on the edge at which the pulse ends.
- R9: On expiry with steering at 1 and interrupt enable (control bit 3) at 1, `int_req_n` is low for exactly 1024 fast ticks. Writing the flag or the interrupt enable to 0 during the pulse neither shortens it nor clears the flag. The flag clears when the pulse ends. The two request outputs are never low together.
- R10: On expiry with steering at 1 and interrupt enable at 0, no pulse is produced. The flag stays set until software writes status bit 0 as 0. Writing it as 1 has no effect.
- R11: A counter load that arrives during a pulse takes effect at once, but counting stays frozen until the pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle enable once per second |
| tick_4096hz | input | 1 | One-cycle enable at 4096 Hz |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Byte offset: 0..2 counter, 3 control, 4 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |
| alarm_flag | output | 1 | Alarm flag (same as status bit 0) |
| rst_req_n | output | 1 | Active-low reset pulse request |
| int_req_n | output | 1 | Active-low interrupt pulse request |
| access_inhibit | output | 1 | High while register access is blocked |

## Verification
The bench checks that a partial counter write leaves the count untouched, since a design that committed byte by byte would show a torn value. It runs each mode against the wrong tick, and a design that ignored the mode bit would count in both. It writes the flag and the interrupt enable to 0 in the middle of an interrupt pulse, then loads the counter during that pulse. A design that let either write through would end the pulse early or drop the flag, and one that counted during the pulse would read back less than the loaded value. It also tries a control write during a reset pulse, and a design that failed to block access would read back the changed control byte afterwards.

// File: rtl/awt_pkg.sv
package awt_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic irq_en;     // bit 3
    logic steer_int;  // bit 2: 0 = reset pulse, 1 = interrupt pulse
    logic wdog_mode;  // bit 1: 0 = alarm, 1 = watchdog
    logic enable;     // bit 0
  } ctrl_t;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_RST  = 2'd1,
    PK_INT  = 2'd2
  } pulse_kind_t;
endpackage

// File: rtl/awt_regs.sv
module awt_regs
  import awt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                inhibit,
  input  logic [CNT_W-1:0]    live,
  input  logic                expire,
  input  logic                pulse_busy,
  input  logic                pulse_done,
  output logic [BYTE_W-1:0]   rdata,
  output ctrl_t               ctrl,
  output logic                flag,
  output logic                load_stb,
  output logic [CNT_W-1:0]    load_val,
  output logic                reload_stb
);
  localparam int NB    = CNT_W / BYTE_W;
  localparam int A_CTL = NB;
  localparam int A_STA = NB + 1;

  logic                        wr_ok, rd_ok, is_cnt;
  logic [NB-2:0][BYTE_W-1:0]   stage;
  logic [NB-1:0][BYTE_W-1:0]   hold;
  logic [BYTE_W-1:0]           hold_sel;

  assign wr_ok  = wr_en & ~inhibit;
  assign rd_ok  = rd_en & ~inhibit;
  assign is_cnt = addr < ADDR_W'(NB);

  // staging bytes below the most significant one
  for (genvar i = 0; i < NB - 1; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        stage[i] <= '0;
      else if (wr_ok && addr == ADDR_W'(i))
        stage[i] <= wdata;
    end
  end

  assign load_stb   = wr_ok && addr == ADDR_W'(NB - 1);
  assign load_val   = {wdata, stage};
  assign reload_stb = ctrl.enable && is_cnt &&
                      ((wr_ok && addr != ADDR_W'(NB - 1)) || rd_ok);

  always_comb begin
    hold_sel = '0;
    for (int i = 0; i < NB; i++)
      if (addr == ADDR_W'(i)) hold_sel = hold[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= '0;
      rdata <= '0;
    end else if (rd_ok) begin
      if (addr == '0) begin
        hold  <= live;
        rdata <= live[BYTE_W-1:0];
      end else if (is_cnt)
        rdata <= hold_sel;
      else if (addr == ADDR_W'(A_CTL))
        rdata <= {{(BYTE_W-4){1'b0}}, ctrl};
      else if (addr == ADDR_W'(A_STA))
        rdata <= {{(BYTE_W-1){1'b0}}, flag};
      else
        rdata <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctrl <= '0;
    else if (wr_ok && addr == ADDR_W'(A_CTL))
      ctrl <= ctrl_t'(wdata[3:0]);
  end

  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (expire)
      flag <= 1'b1;
    else if (pulse_done)
      flag <= 1'b0;
    else if (wr_ok && addr == ADDR_W'(A_STA) && !wdata[0] && !pulse_busy)
      flag <= 1'b0;
  end
endmodule

// File: rtl/awt_counter.sv
module awt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             wdog_mode,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             freeze,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload_stb,
  output logic [CNT_W-1:0] live,
  output logic             expire
);
  logic [CNT_W-1:0] seed;
  logic             running;
  logic             step;

  assign step = enable && running && !freeze &&
                (wdog_mode ? tick_fast : tick_slow);

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= '0;
      seed    <= '0;
      running <= 1'b0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load_stb) begin
        live    <= load_val;
        seed    <= load_val;
        running <= |load_val;
      end else if (reload_stb) begin
        live    <= seed;
        running <= |seed;
      end else if (step) begin
        if (live == CNT_W'(1)) begin
          expire <= 1'b1;
          if (wdog_mode) begin
            live    <= '0;
            running <= 1'b0;
          end else begin
            live <= seed;
          end
        end else begin
          live <= live - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/awt_pulse.sv
module awt_pulse
  import awt_pkg::*;
#(
  parameter int PULSE_TICKS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_fast,
  input  logic expire,
  input  logic steer_int,
  input  logic irq_en,
  output logic busy,
  output logic done,
  output logic rst_n_o,
  output logic int_n_o,
  output logic inhibit_o
);
  localparam int CW = $clog2(PULSE_TICKS + 1);

  pulse_kind_t   kind;
  logic [CW-1:0] cnt;

  assign busy = kind != PK_NONE;
  assign done = busy && tick_fast && cnt == CW'(PULSE_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind      <= PK_NONE;
      cnt       <= '0;
      rst_n_o   <= 1'b1;
      int_n_o   <= 1'b1;
      inhibit_o <= 1'b0;
    end else if (!busy) begin
      cnt <= '0;
      if (expire) begin
        if (!steer_int) begin
          kind      <= PK_RST;
          rst_n_o   <= 1'b0;
          inhibit_o <= 1'b1;
        end else if (irq_en) begin
          kind    <= PK_INT;
          int_n_o <= 1'b0;
        end
      end
    end else if (tick_fast) begin
      cnt <= cnt + CW'(1);
      if (done) begin
        kind      <= PK_NONE;
        rst_n_o   <= 1'b1;
        int_n_o   <= 1'b1;
        inhibit_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/awt_top.sv
module awt_top
  import awt_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int ADDR_W      = 3,
  parameter int PULSE_TICKS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              tick_4096hz,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              alarm_flag,
  output logic              rst_req_n,
  output logic              int_req_n,
  output logic              access_inhibit
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] live, load_val;
  logic             load_stb, reload_stb, expire, busy, done;

  awt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .inhibit(access_inhibit), .live(live), .expire(expire),
    .pulse_busy(busy), .pulse_done(done), .rdata(rdata), .ctrl(ctrl),
    .flag(alarm_flag), .load_stb(load_stb), .load_val(load_val),
    .reload_stb(reload_stb)
  );

  awt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .enable(ctrl.enable), .wdog_mode(ctrl.wdog_mode),
    .tick_slow(tick_1hz), .tick_fast(tick_4096hz), .freeze(busy),
    .load_stb(load_stb), .load_val(load_val), .reload_stb(reload_stb),
    .live(live), .expire(expire)
  );

  awt_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst(rst), .tick_fast(tick_4096hz), .expire(expire),
    .steer_int(ctrl.steer_int), .irq_en(ctrl.irq_en), .busy(busy),
    .done(done), .rst_n_o(rst_req_n), .int_n_o(int_req_n),
    .inhibit_o(access_inhibit)
  );
endmodule

// File: rtl/awt_checker.sv
module awt_checker #(
  parameter int PULSE_TICKS = 1024
) (
  input logic clk,
  input logic rst,
  input logic tick_fast,
  input logic flag,
  input logic rst_n,
  input logic int_n
);
  logic [31:0] cnt_r, cnt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_r <= '0;
      cnt_i <= '0;
    end else begin
      cnt_r <= !rst_n ? cnt_r + 32'(tick_fast) : '0;
      cnt_i <= !int_n ? cnt_i + 32'(tick_fast) : '0;
    end
  end

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    !(!rst_n && !int_n));
  p_flag_at_rst_start_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n) |-> flag);
  p_flag_at_int_start_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> flag);
  p_rst_len_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n) |-> cnt_r == 32'(PULSE_TICKS));
  p_int_len_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(int_n) |-> cnt_i == 32'(PULSE_TICKS));
  p_flag_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n) |-> !flag);
endmodule

bind awt_top awt_checker #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
  .clk(clk), .rst(rst), .tick_fast(tick_4096hz), .flag(alarm_flag),
  .rst_n(rst_req_n), .int_n(int_req_n)
);

// File: tb/sim_awt_top.sv
module sim_awt_top;
  localparam int PT = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0, tick_4096hz = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       alarm_flag, rst_req_n, int_req_n, access_inhibit;
  int         checks = 0, errors = 0;

  always #4 clk = ~clk;

  awt_top u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .tick_4096hz(tick_4096hz),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .alarm_flag(alarm_flag), .rst_req_n(rst_req_n), .int_req_n(int_req_n),
    .access_inhibit(access_inhibit)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_cnt(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    rd(3'd0, b0); rd(3'd1, b1); rd(3'd2, b2);
    v = {b2, b1, b0};
  endtask

  task automatic wr_cnt(logic [23:0] v);
    wr(3'd0, v[7:0]); wr(3'd1, v[15:8]); wr(3'd2, v[23:16]);
  endtask

  task automatic tick1(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
    end
    idle(2);
  endtask

  task automatic tick4(int n);
    @(negedge clk); tick_4096hz = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); tick_4096hz = 1'b0;
    idle(2);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [23:0] v;
    check("R1 rst_req_n", rst_req_n, 1);
    check("R1 int_req_n", int_req_n, 1);
    check("R1 inhibit", access_inhibit, 0);
    rd(3'd3, d); check("R1 control", d, 0);
    rd(3'd4, d); check("R1 status", d, 0);
    rd_cnt(v); check("R1 counter", v, 0);
  endtask

  task automatic t_storage();
    logic [23:0] v;
    wr_cnt(24'h332211);
    tick1(3); tick4(5);
    rd_cnt(v); check("R6 no count when disabled", v, 24'h332211);
    wr(3'd0, 8'hAA);
    rd_cnt(v); check("R2 low byte only staged", v, 24'h332211);
    wr(3'd1, 8'hBB); wr(3'd2, 8'hCC);
    rd_cnt(v); check("R2 atomic commit", v, 24'hCCBBAA);
  endtask

  task automatic t_alarm();
    logic [7:0] d;
    wr(3'd3, 8'h05);
    wr_cnt(24'd3);
    tick4(10); tick1(2);
    rd(3'd4, d); check("R3 no flag before zero", d, 0);
    tick1(1);
    rd(3'd4, d); check("R3 flag at zero", d, 1);
    check("R10 no int pulse", int_req_n, 1);
    check("R3 no reset pulse", rst_req_n, 1);
    tick1(2);
    rd(3'd0, d); check("R3 reload and continue", d, 1);
    wr(3'd4, 8'h00);
    rd(3'd4, d); check("R10 software clear", d, 0);
  endtask

  task automatic t_reload();
    logic [7:0] d;
    wr_cnt(24'd10);
    tick1(4);
    wr(3'd0, 8'h00);
    tick1(1);
    rd(3'd0, d); check("R5 write restarts from seed", d, 9);
    rd(3'd0, d); check("R5 read restarts from seed", d, 10);
  endtask

  task automatic t_zero();
    logic [7:0] d; logic [23:0] v;
    wr_cnt(24'd0);
    tick1(5); tick4(5);
    rd(3'd4, d); check("R7 zero load no flag", d, 0);
    rd_cnt(v); check("R7 zero load stays", v, 0);
  endtask

  task automatic t_wdog();
    logic [7:0] d;
    wr(3'd3, 8'h03);
    wr_cnt(24'd5);
    tick1(10);
    rd(3'd4, d); check("R4 slow tick ignored", d, 0);
    tick4(5);
    check("R8 reset pulse low", rst_req_n, 0);
    check("R8 access inhibited", access_inhibit, 1);
    check("R8 no int pulse", int_req_n, 1);
    wr(3'd3, 8'h00);
    tick4(PT - 1);
    check("R8 pulse not yet over", rst_req_n, 0);
    tick4(1);
    check("R8 pulse released", rst_req_n, 1);
    check("R8 access restored", access_inhibit, 0);
    rd(3'd3, d); check("R8 write blocked during pulse", d, 8'h03);
    rd(3'd4, d); check("R8 flag cleared at end", d, 0);
    tick4(3);
    rd(3'd0, d); check("R4 stopped at zero", d, 0);
  endtask

  task automatic t_int();
    logic [7:0] d;
    wr(3'd3, 8'h0F);
    wr_cnt(24'd4);
    tick4(4);
    check("R9 int pulse low", int_req_n, 0);
    check("R9 reset stays high", rst_req_n, 1);
    check("R9 no inhibit", access_inhibit, 0);
    wr(3'd4, 8'h00);
    wr(3'd3, 8'h07);
    tick4(10);
    check("R9 pulse not shortened", int_req_n, 0);
    rd(3'd4, d); check("R9 flag held in pulse", d, 1);
    wr_cnt(24'd2);
    tick4(PT - 11);
    check("R9 still low before end", int_req_n, 0);
    rd(3'd0, d); check("R11 frozen during pulse", d, 2);
    tick4(1);
    check("R9 pulse ends", int_req_n, 1);
    rd(3'd4, d); check("R9 flag clears at end", d, 0);
    tick4(2);
    rd(3'd4, d); check("R10 flag set", d, 1);
    check("R10 no pulse with irq off", int_req_n, 1);
    tick4(5);
    wr(3'd4, 8'h01);
    rd(3'd4, d); check("R10 write one ignored", d, 1);
    wr(3'd4, 8'h00);
    rd(3'd4, d); check("R10 write zero clears", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_storage();
    t_alarm();
    t_reload();
    t_zero();
    t_wdog();
    t_int();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule